// File: doc/BRIEF.md
# Biphase Serial Word Encoder

This block turns 16-bit words into the line waveform of a 1 Mb/s command/response serial bus. Each word is framed as 20 bit times. The first three bit times carry a sync pattern whose polarity tells command/status words apart from data words. Sixteen payload bits follow, most significant first, in biphase (Manchester II) coding. A generated parity bit closes the frame. The encoder adds the sync and the parity itself. The host supplies only the payload and a one-bit word-type flag.

The line is shown as two drive enables, one for each polarity of the differential driver. Both enables are low while nothing is being sent. A one-word holding register sits behind a ready/start handshake. While one word is on the line, the host can queue the next word, and that word then follows with no idle time in between. The module runs from a clock at an integer multiple of 2 MHz. The parameter `HALF_DIV` gives the number of clock cycles in one half bit time.

Top module: `biph_word_encoder`

## Requirements
- R1: After reset, and whenever no word is on the line, `driveHi` and `driveLo` are both 0. `readyOut` is 1 after reset.
- R2: A word with `isData`=0 (command/status) starts with 3 half-bit intervals of level high (`driveHi`=1), then 3 half-bit intervals of level low (`driveLo`=1).
- R3: A word with `isData`=1 starts with the inverse sync: 3 half-bit intervals low, then 3 high.
- R4: After the sync, the 16 payload bits go out starting at bit 15 and ending at bit 0. A 1 is sent as high then low, and a 0 as low then high, each half lasting one half-bit interval.
- R5: The 20th bit time carries a parity bit in the same biphase coding. The parity bit is chosen so that the 16 payload bits plus parity hold an odd number of ones.
- R6: Every half-bit interval lasts exactly `HALF_DIV` clock cycles, so a word holds the line for 40·`HALF_DIV` cycles.
- R7: A word is accepted on a clock edge where `startIn` and `readyOut` are both 1. `readyOut` is 0 on the next cycle, and stays 0 while a word is held waiting. While `readyOut` is 0, `startIn` has no effect and no word is queued.
- R8: If a word is held when the current word's last half-bit ends, the held word's first sync interval begins on the next cycle, with no idle cycle.
- R9: `driveHi` and `driveLo` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 2 MHz × `HALF_DIV` |
| rstN | input | 1 | Active-low synchronous reset |
| wordIn | input | 16 | Payload word to send |
| isData | input | 1 | 1 = data word sync, 0 = command/status sync |
| startIn | input | 1 | Request to accept `wordIn`/`isData` |
| readyOut | output | 1 | Holding register free, start will be accepted |
| driveHi | output | 1 | Drive the line to the high level |
| driveLo | output | 1 | Drive the line to the low level |

## Verification
Suppose the half-bit index or the divider slips. The next half-bit boundary then lands on the wrong clock cycle, and the first bad cycle is visible on the drive pins. For that reason the bench compares both drives on every cycle of every word. A shift register that is stale or shifted by one shows up as a biphase half with the wrong sense at the first payload bit that differs. A wrong parity state appears only in the last two halves of the frame. A holding register that is lost or left set shows up as an idle gap between queued words, as an extra frame, or as `readyOut` stuck low.

// File: rtl/biph_pkg.sv
package biph_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // move held word into the shifter, frame starts next cycle
    logic shift;  // advance to the next payload bit
  } biph_strobe_t;
endpackage

// File: rtl/biph_ctrl.sv
module biph_ctrl #(
  parameter int HALF_DIV  = 25,
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pendValid,
  output biph_pkg::biph_strobe_t strobe,
  output logic active,
  output logic [$clog2(2*(SYNC_BITS+DATA_W+1))-1:0] halfIdx
);
  localparam int SYNC_HALVES  = 2 * SYNC_BITS;
  localparam int TOTAL_HALVES = 2 * (SYNC_BITS + DATA_W + 1);
  localparam int HW           = $clog2(TOTAL_HALVES);
  localparam int DIV_W        = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HW-1:0]    LAST_H    = HW'(TOTAL_HALVES - 1);
  localparam logic [HW-1:0]    FIRST_SH  = HW'(SYNC_HALVES + 1);
  localparam logic [HW-1:0]    LAST_SH   = HW'(SYNC_HALVES + 2 * DATA_W - 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic tick, lastHalf;

  assign tick     = active && (divCnt == DIV_LAST);
  assign lastHalf = (halfIdx == LAST_H);

  always_comb begin
    strobe.load  = pendValid && (!active || (tick && lastHalf));
    strobe.shift = tick && halfIdx[0] && (halfIdx >= FIRST_SH) && (halfIdx <= LAST_SH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      halfIdx <= '0;
      divCnt  <= '0;
    end else if (strobe.load) begin
      active  <= 1'b1;
      halfIdx <= '0;
      divCnt  <= '0;
    end else if (tick) begin
      divCnt <= '0;
      if (lastHalf) begin
        active  <= 1'b0;
        halfIdx <= '0;
      end else begin
        halfIdx <= halfIdx + 1'b1;
      end
    end else if (active) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // R6: inside a frame each half boundary steps the index by exactly one
  assert_half_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !lastHalf) |=> (active && halfIdx == $past(halfIdx) + 1'b1));

  // R8: a held word at the end of the last half restarts the frame at once
  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tick && lastHalf && pendValid) |=> (active && halfIdx == '0 && divCnt == '0));

  // R1: an idle sequencer with nothing held stays idle
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !pendValid) |=> !active);
endmodule

// File: rtl/biph_datapath.sv
module biph_datapath #(
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic [DATA_W-1:0] wordIn,
  input  logic isData,
  input  logic startIn,
  input  biph_pkg::biph_strobe_t strobe,
  input  logic active,
  input  logic [$clog2(2*(SYNC_BITS+DATA_W+1))-1:0] halfIdx,
  output logic pendValid,
  output logic readyOut,
  output logic driveHi,
  output logic driveLo
);
  localparam int SYNC_HALVES  = 2 * SYNC_BITS;
  localparam int TOTAL_HALVES = 2 * (SYNC_BITS + DATA_W + 1);
  localparam int HW           = $clog2(TOTAL_HALVES);
  localparam logic [HW-1:0] SYNC_END = HW'(SYNC_HALVES);
  localparam logic [HW-1:0] SYNC_MID = HW'(SYNC_BITS);
  localparam logic [HW-1:0] DATA_END = HW'(SYNC_HALVES + 2 * DATA_W);

  logic [DATA_W-1:0] pendWord, shiftReg;
  logic pendData, curData, curParity;
  logic accept, bitVal, level;

  assign readyOut = !pendValid;
  assign accept   = startIn && readyOut;

  // Holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendWord  <= '0;
      pendData  <= 1'b0;
    end else if (strobe.load) begin
      pendValid <= 1'b0;
    end else if (accept) begin
      pendValid <= 1'b1;
      pendWord  <= wordIn;
      pendData  <= isData;
    end
  end

  // Output shifter and frame attributes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      curData   <= 1'b0;
      curParity <= 1'b0;
    end else if (strobe.load) begin
      shiftReg  <= pendWord;
      curData   <= pendData;
      curParity <= ~^pendWord;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  // Line level for the current half-bit
  always_comb begin
    bitVal = (halfIdx < DATA_END) ? shiftReg[DATA_W-1] : curParity;
    if (halfIdx < SYNC_END)
      level = (halfIdx < SYNC_MID) ^ curData;
    else
      level = halfIdx[0] ? !bitVal : bitVal;
  end

  assign driveHi = active && level;
  assign driveLo = active && !level;

  // R7: an accepted word closes the handshake on the next cycle
  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && readyOut) |=> !readyOut);

  // R7: a held word is not overwritten while waiting
  assert_pend_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !strobe.load) |=> ($stable(pendWord) && $stable(pendData)));

  // R4: the shifter moves payload toward the MSB one place per bit
  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (shiftReg[DATA_W-1] == $past(shiftReg[DATA_W-2])));

  // R2: a command/status frame opens at the high level
  assert_cmd_sync_R2: assert property (@(posedge clk) disable iff (!rstN)
    (active && halfIdx == '0 && !curData) |-> (driveHi && !driveLo));

  // R9: never both drives
  assert_one_drive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(driveHi && driveLo));
endmodule

// File: rtl/biph_word_encoder.sv
module biph_word_encoder #(
  parameter int HALF_DIV  = 25,
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wordIn,
  input  logic              isData,
  input  logic              startIn,
  output logic              readyOut,
  output logic              driveHi,
  output logic              driveLo
);
  localparam int HW = $clog2(2 * (SYNC_BITS + DATA_W + 1));

  biph_pkg::biph_strobe_t strobe;
  logic          active;
  logic          pendValid;
  logic [HW-1:0] halfIdx;

  biph_ctrl #(.HALF_DIV(HALF_DIV), .DATA_W(DATA_W), .SYNC_BITS(SYNC_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .pendValid(pendValid),
    .strobe(strobe), .active(active), .halfIdx(halfIdx));

  biph_datapath #(.DATA_W(DATA_W), .SYNC_BITS(SYNC_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .isData(isData), .startIn(startIn),
    .strobe(strobe), .active(active), .halfIdx(halfIdx),
    .pendValid(pendValid), .readyOut(readyOut), .driveHi(driveHi), .driveLo(driveLo));
endmodule

// File: tb/test_biph_word_encoder.sv
module test_biph_word_encoder;
  localparam int HD = 3;
  localparam int HALVES = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] wordIn = '0;
  logic isData = 1'b0;
  logic startIn = 1'b0;
  logic readyOut, driveHi, driveLo;

  always #2 clk = ~clk;

  biph_word_encoder #(.HALF_DIV(HD)) i_biph_word_encoder (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .isData(isData), .startIn(startIn),
    .readyOut(readyOut), .driveHi(driveHi), .driveLo(driveLo));

  int testCnt = 0;
  int failCnt = 0;

  logic [15:0] expWord [0:63];
  logic        expData [0:63];
  int          gapLog  [0:63];
  int wrIdx = 0;
  int rdIdx = 0;

  // Expected line level for half h of a frame
  function automatic logic expLevel(int h, logic [15:0] w, logic d);
    logic b;
    if (h < 6) return (h < 3) ^ d;
    if (h < 38) b = w[15 - (h - 6) / 2];
    else        b = ~^w;
    return (h % 2 == 1) ? !b : b;
  endfunction

  function automatic string regionReq(int h, logic d);
    if (h < 6) return d ? "R3" : "R2";
    if (h < 38) return "R4";
    return "R5";
  endfunction

  // Monitor: checks every cycle of every frame
  logic inWord = 1'b0;
  int h = 0, c = 0, gapCnt = 0, runLen = 0, lastRun = 0;
  int errH = -1;
  logic errAct = 1'b0, errExp = 1'b0;
  int bothErr = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (driveHi && driveLo) bothErr++;
      if (driveHi || driveLo) runLen++;
      else if (runLen != 0) begin lastRun = runLen; runLen = 0; end
      if (!inWord) begin
        if (driveHi || driveLo) begin
          inWord = 1'b1; h = 0; c = 0; errH = -1;
          if (rdIdx >= wrIdx) begin
            testCnt++; failCnt++;
            $display("FAIL R7 unexpected frame: actual frame started, expected idle");
            expWord[rdIdx % 64] = '0; expData[rdIdx % 64] = 1'b0;
          end
          gapLog[rdIdx % 64] = gapCnt;
          gapCnt = 0;
        end else gapCnt++;
      end
      if (inWord) begin
        if (errH < 0 && (driveHi != expLevel(h, expWord[rdIdx%64], expData[rdIdx%64]) ||
                         driveLo == driveHi)) begin
          errH = h; errAct = driveHi;
          errExp = expLevel(h, expWord[rdIdx%64], expData[rdIdx%64]);
        end
        c++;
        if (c == HD) begin
          c = 0; h++;
          if (h == HALVES) begin
            testCnt++;
            if (errH >= 0) begin
              failCnt++;
              $display("FAIL %s/R6 word %04h data=%0d half %0d: actual hi=%0d expected hi=%0d",
                       regionReq(errH, expData[rdIdx%64]), expWord[rdIdx%64],
                       expData[rdIdx%64], errH, errAct, errExp);
            end
            rdIdx++; inWord = 1'b0;
          end
        end
      end
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [15:0] w, input logic d);
    while (!readyOut) @(negedge clk);
    wordIn = w; isData = d; startIn = 1'b1;
    expWord[wrIdx % 64] = w; expData[wrIdx % 64] = d; wrIdx++;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic drain();
    while (rdIdx < wrIdx || inWord || !readyOut) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failCnt++; testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int idxB;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!driveHi && !driveLo, "R1 idle drives after reset", driveHi + driveLo, 0);
    check(readyOut, "R1 ready after reset", readyOut, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Directed words, isolated; R6 frame length
    sendWord(16'h0000, 1'b0); drain();
    check(lastRun == HALVES * HD, "R6 frame length", lastRun, HALVES * HD);
    check(!driveHi && !driveLo, "R1 idle after frame", driveHi + driveLo, 0);
    sendWord(16'hFFFF, 1'b1); drain();          // R3 data sync, R5 parity with even ones
    sendWord(16'h8001, 1'b0); drain();          // R4 MSB first
    sendWord(16'hA5A4, 1'b1); drain();          // R5 odd ones count

    // R7 and R8: two words back to back, then a start while busy
    sendWord(16'h1234, 1'b0);
    idxB = wrIdx;
    sendWord(16'hFEDC, 1'b1);
    check(!readyOut, "R7 ready low with word held", readyOut, 0);
    wordIn = 16'h5555; isData = 1'b0; startIn = 1'b1;   // must be ignored
    @(negedge clk);
    startIn = 1'b0;
    check(!readyOut, "R7 ready still low after ignored start", readyOut, 0);
    drain();
    check(gapLog[idxB % 64] == 0, "R8 gap before queued word", gapLog[idxB % 64], 0);
    check(lastRun == 2 * HALVES * HD, "R8 contiguous run", lastRun, 2 * HALVES * HD);
    check(rdIdx == wrIdx, "R7 frame count", rdIdx, wrIdx);

    // Random words with random spacing
    for (int i = 0; i < 24; i++) begin
      sendWord(16'($urandom), 1'($urandom));
      if ($urandom % 3 == 0) repeat ($urandom % 200) @(negedge clk);
    end
    drain();
    check(rdIdx == wrIdx, "R7 random frame count", rdIdx, wrIdx);
    check(bothErr == 0, "R9 both drives high cycles", bothErr, 0);
    check(!driveHi && !driveLo && readyOut, "R1 final idle", driveHi + driveLo, 0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule